// File: doc/BRIEF.md
# Framing serial-to-parallel demultiplexer

This block converts a serial bit stream, one bit per clock, into 32-bit parallel words. The earliest bit of each word lands in bit 31. Each word goes out on `word_o` with a one-cycle strobe, together with a parity bit over that word. The parity sense, odd or even, is chosen by an input.

While the framer hunts, a 16-bit sliding window watches the stream for the boundary between an A1 framing byte (0xF6) and an A2 framing byte (0x28). Only the two most significant bits of each byte are compared. When the window matches, the bit counter reloads so that the next word starts with the bit right after the A2 byte. Any partial word is dropped, so the strobe period stretches once. The first word on the new boundary carries a sync pulse.

Once a frame has been found, driving `hold_i` high freezes the boundary. Without framing patterns the block is a plain 1:32 demultiplexer with an unbroken strobe cadence.

The controller has three states:
- `ST_HUNT`: no frame found yet.
- `ST_ALIGN`: the boundary was just moved, and the first word on it has not been delivered.
- `ST_LOCK`: at least one word has been delivered on the current boundary.

Its transitions are:
- HUNT→ALIGN on a match.
- ALIGN→ALIGN or LOCK→ALIGN on a match that `hold_i` does not block.
- ALIGN→LOCK when a word completes with no new match.
- Any state→HUNT on reset.

Top module: `sdh_frame_demux`

## Requirements
- R1: Each output word holds 32 consecutive serial bits; `word_o[31]` is the earliest received and `word_o[0]` the latest.
- R2: While `rst_i` is high, all outputs are zero and the block returns to `ST_HUNT` with the bit count at zero. After release, the first strobe follows the 32nd sampled bit.
- R3: With no match, `strb_o` pulses exactly once every 32 cycles. A realignment can only lengthen the spacing between strobes, never shorten it.
- R4: A match occurs when the bits received 15 and 14 cycles before the current bit are both 1 and the bits received 7 and 6 cycles before it are both 0. A pattern that fails either pair causes no realignment.
- R5: On an accepted match, the bit count restarts at zero. The next word is the 32 bits after the current bit, and a partial word in progress is discarded.
- R6: `sync_o` is high only together with `strb_o`, and only on the first word delivered after an accepted match.
- R7: In `ST_ALIGN` or `ST_LOCK`, a match while `hold_i` is high is ignored: the boundary, the cadence and `sync_o` are unchanged.
- R8: In `ST_HUNT`, `hold_i` has no effect and a match is always accepted.
- R9: `par_odd_i`=1 makes the count of ones in {`word_o`,`par_o`} odd; `par_odd_i`=0 makes it even. The value of `par_odd_i` is taken on the cycle that the word's last bit is sampled.
- R10: `par_o` and `word_o` update on the same edge and stay valid together while `strb_o` is high.
- R11: `strb_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_i | input | 1 | Synchronous active-high reset, restarts the frame search |
| ser_i | input | 1 | Serial data, one bit per clock |
| hold_i | input | 1 | High freezes the boundary once a frame is found |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| word_o | output | 32 | Parallel word, bit 31 earliest |
| strb_o | output | 1 | One-cycle pulse when a new word is on `word_o` |
| sync_o | output | 1 | Pulse with the first word after realignment |
| par_o | output | 1 | Parity bit for `word_o` |

## Verification
The assertions assume that `ser_i`, `hold_i` and `par_odd_i` change only between clock edges. They also assume reset is held for at least one edge before the stream starts. The bench drives every input on the falling edge and holds reset for several cycles.

Background data is generated with no two adjacent ones, so no match can arise outside the framing and near-miss patterns the bench places on purpose. A zero bit always precedes each inserted pattern, so each match lands at a known bit position. `hold_i` is raised before any payload that could form a second match.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    localparam int BYTE_W = 8;
    localparam int WIN_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_LOCK  = 2'd2
    } sfd_state_e;
endpackage

// File: rtl/sfd_shift.sv
module sfd_shift #(
    parameter int WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ser_i,
    output logic [WORD_W-1:0] word_now_o
);
    // History of the previous WORD_W-1 bits; the newest bit joins combinationally
    logic [WORD_W-2:0] hist_q;

    assign word_now_o = {hist_q, ser_i};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hist_q <= '0;
        end else begin
            hist_q <= word_now_o[WORD_W-2:0];
        end
    end
endmodule

// File: rtl/sfd_detect.sv
module sfd_detect import sfd_pkg::*; #(
    parameter logic [BYTE_W-1:0] A1_PAT    = 8'hF6,
    parameter logic [BYTE_W-1:0] A2_PAT    = 8'h28,
    parameter logic [BYTE_W-1:0] PICK_MASK = 8'hC0
) (
    input  logic [WIN_W-1:0] win_i,
    output logic             match_o
);
    logic [BYTE_W-1:0] a1_ok;
    logic [BYTE_W-1:0] a2_ok;

    // Older byte of the window is compared with A1, newer byte with A2
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign a1_ok[i] = ((win_i[BYTE_W+i] ^ A1_PAT[i]) & PICK_MASK[i]) == 1'b0;
        assign a2_ok[i] = ((win_i[i] ^ A2_PAT[i]) & PICK_MASK[i]) == 1'b0;
    end

    assign match_o = (&a1_ok) && (&a2_ok);
endmodule

// File: rtl/sfd_ctrl.sv
module sfd_ctrl import sfd_pkg::*; #(
    parameter int WORD_W = 32
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic match_i,
    input  logic hold_i,
    output logic word_end_o,
    output logic align_o
);
    localparam int            CW   = $clog2(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    sfd_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          realign;
    logic          word_end;

    // Hold only blocks a match after a frame has been found
    assign realign  = match_i && !((state_q != ST_HUNT) && hold_i);
    assign word_end = (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (realign) state_d = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (realign)       state_d = ST_ALIGN;
                else if (word_end) state_d = ST_LOCK;
            end
            ST_LOCK: begin
                if (realign) state_d = ST_ALIGN;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (realign || word_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        word_end_o = word_end;
        align_o    = (state_q == ST_ALIGN);
    end

    AST_HUNT_WAIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_HUNT && !match_i) |=> (state_q == ST_HUNT)); // R4
    AST_REALIGN: assert property (@(posedge clk_i) disable iff (rst_i)
        (match_i && !hold_i) |=> (state_q == ST_ALIGN && cnt_q == '0)); // R5
    AST_LOCK_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LOCK && hold_i) |=> (state_q == ST_LOCK)); // R7
    AST_HUNT_ACCEPT: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_HUNT && match_i) |=> (state_q == ST_ALIGN)); // R8
    AST_ALIGN_EXIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_ALIGN && word_end && !match_i) |=> (state_q == ST_LOCK)); // R6
endmodule

// File: rtl/sfd_out.sv
module sfd_out #(
    parameter int WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              word_end_i,
    input  logic              align_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              par_odd_i,
    output logic [WORD_W-1:0] word_o,
    output logic              strb_o,
    output logic              sync_o,
    output logic              par_o
);
    localparam int CW = $clog2(WORD_W);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            word_o <= '0;
            strb_o <= 1'b0;
            sync_o <= 1'b0;
            par_o  <= 1'b0;
        end else begin
            strb_o <= word_end_i;
            sync_o <= word_end_i && align_i;
            if (word_end_i) begin
                word_o <= word_i;
                par_o  <= (^word_i) ^ par_odd_i;
            end
        end
    end

    // Spacing monitor for the cadence check
    logic [CW:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (strb_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q < (CW+1)'(WORD_W)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_STRB_SPACING: assert property (@(posedge clk_i) disable iff (rst_i)
        (strb_o && seen_q) |-> (gap_q >= (CW+1)'(WORD_W - 1))); // R3
    AST_STRB_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        strb_o |=> !strb_o); // R11
    AST_SYNC_STROBED: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_o |-> strb_o); // R6
    AST_PARITY_SENSE: assert property (@(posedge clk_i) disable iff (rst_i)
        strb_o |-> (((^word_o) ^ par_o) == $past(par_odd_i))); // R9
endmodule

// File: rtl/sdh_frame_demux.sv
module sdh_frame_demux import sfd_pkg::*; #(
    parameter int                WORD_W    = 32,
    parameter logic [BYTE_W-1:0] A1_PAT    = 8'hF6,
    parameter logic [BYTE_W-1:0] A2_PAT    = 8'h28,
    parameter logic [BYTE_W-1:0] PICK_MASK = 8'hC0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ser_i,
    input  logic              hold_i,
    input  logic              par_odd_i,
    output logic [WORD_W-1:0] word_o,
    output logic              strb_o,
    output logic              sync_o,
    output logic              par_o
);
    logic [WORD_W-1:0] word_now;
    logic              match;
    logic              word_end;
    logic              align;

    sfd_shift #(.WORD_W(WORD_W)) u_shift (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ser_i      (ser_i),
        .word_now_o (word_now)
    );

    sfd_detect #(
        .A1_PAT    (A1_PAT),
        .A2_PAT    (A2_PAT),
        .PICK_MASK (PICK_MASK)
    ) u_detect (
        .win_i   (word_now[WIN_W-1:0]),
        .match_o (match)
    );

    sfd_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .match_i    (match),
        .hold_i     (hold_i),
        .word_end_o (word_end),
        .align_o    (align)
    );

    sfd_out #(.WORD_W(WORD_W)) u_out (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .word_end_i (word_end),
        .align_i    (align),
        .word_i     (word_now),
        .par_odd_i  (par_odd_i),
        .word_o     (word_o),
        .strb_o     (strb_o),
        .sync_o     (sync_o),
        .par_o      (par_o)
    );
endmodule

// File: tb/sim_sdh_frame_demux.sv
module sim_sdh_frame_demux;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser = 1'b0;
    logic        hold = 1'b0;
    logic        par_odd = 1'b0;
    logic [31:0] word_o;
    logic        strb_o, sync_o, par_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sdh_frame_demux u0 (
        .clk_i(clk), .rst_i(rst), .ser_i(ser), .hold_i(hold), .par_odd_i(par_odd),
        .word_o(word_o), .strb_o(strb_o), .sync_o(sync_o), .par_o(par_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated on every rising edge
    bit          m_hist[$];
    int          m_cnt = 0;
    int          m_st = 0;   // 0 hunting, 1 just aligned, 2 locked
    logic        e_strb = 0, e_sync = 0, e_par = 0;
    logic [31:0] e_word = '0;

    always @(posedge clk) begin
        logic [31:0] wd;
        bit          mt, ra;
        if (rst) begin
            m_hist = {};
            for (int i = 0; i < 32; i++) m_hist.push_back(1'b0);
            m_cnt = 0; m_st = 0;
            e_strb = 0; e_sync = 0; e_par = 0; e_word = '0;
        end else begin
            m_hist.push_back(ser);
            void'(m_hist.pop_front());
            wd = '0;
            for (int i = 0; i < 32; i++) wd = {wd[30:0], m_hist[i]};
            mt = (wd[15:14] == 2'b11) && (wd[7:6] == 2'b00);
            ra = mt && !(m_st != 0 && hold);
            e_strb = (m_cnt == 31);
            e_sync = e_strb && (m_st == 1);
            if (e_strb) begin
                e_word = wd;
                e_par  = (^wd) ^ par_odd;
            end
            if (ra) begin
                m_st = 1; m_cnt = 0;
            end else begin
                if (m_cnt == 31 && m_st == 1) m_st = 2;
                m_cnt = (m_cnt == 31) ? 0 : m_cnt + 1;
            end
        end
    end

    // Output monitor on the falling edge
    int          n_strb = 0, n_sync = 0, cyc_since = 0, last_gap = 0, max_gap = 0;
    bit          have_prev = 0;
    logic [31:0] last_word = '0;
    logic        last_par = 0;

    always @(negedge clk) begin
        if (rst) begin
            n_strb = 0; n_sync = 0; cyc_since = 0; have_prev = 0; max_gap = 0;
        end else begin
            chk(strb_o == e_strb, "R3 R11 strobe", {31'd0, strb_o}, {31'd0, e_strb});
            chk(sync_o == e_sync, "R6 sync", {31'd0, sync_o}, {31'd0, e_sync});
            if (e_strb) begin
                chk(word_o == e_word, "R1 word", word_o, e_word);
                chk(par_o == e_par, "R9 R10 parity", {31'd0, par_o}, {31'd0, e_par});
            end
            if (strb_o) begin
                if (have_prev) begin
                    last_gap = cyc_since + 1;
                    if (last_gap > max_gap) max_gap = last_gap;
                end
                have_prev = 1; cyc_since = 0; n_strb++;
                if (sync_o) n_sync++;
                last_word = word_o; last_par = par_o;
            end else begin
                cyc_since++;
            end
        end
    end

    bit prev = 0;

    task automatic send_bit(input logic b);
        ser = b; prev = b;
        @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    // Background data: never two adjacent ones, so it cannot match
    task automatic send_plain(input int n);
        for (int i = 0; i < n; i++) send_bit(logic'($urandom_range(0, 1)) & ~prev);
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        #1;
        chk(word_o == 0 && !strb_o && !sync_o && !par_o, "R2 reset outputs",
            {word_o[31:3], strb_o, sync_o, par_o}, 32'd0);
        rst = 0; prev = 0;
    endtask

    initial begin
        @(negedge clk);
        // Plain demultiplexing after reset
        hold = 0;
        do_reset();
        send_bits(32'h9249_2492, 32);
        #1;
        chk(strb_o == 1'b1, "R2 first strobe after 32 bits", {31'd0, strb_o}, 32'd1);
        chk(word_o == 32'h9249_2492, "R1 bit order", word_o, 32'h9249_2492);
        send_plain(15); send_bit(0);
        send_bits(32'h0000_C040, 16);          // near miss: A2 pair not 00
        send_plain(64);
        #1;
        chk(n_strb == 4, "R3 strobe count", n_strb, 4);
        chk(last_gap == 32, "R3 steady cadence", last_gap, 32);
        chk(n_sync == 0, "R4 near miss ignored", n_sync, 0);

        // Frame at an offset: realignment, stretch and sync
        send_plain(6); send_bit(0);
        send_bits(32'h0000_F628, 16);
        hold = 1;
        send_bits(32'hDEAD_BEEF, 32);
        #1;
        chk(strb_o && sync_o, "R6 sync with first aligned word", {30'd0, strb_o, sync_o}, 32'd3);
        chk(word_o == 32'hDEAD_BEEF, "R5 word after framing", word_o, 32'hDEAD_BEEF);
        chk(last_gap > 32, "R5 stretched period", last_gap, 33);
        send_plain(64);
        #1;
        chk(n_sync == 1, "R6 single sync pulse", n_sync, 1);

        // Locked with hold high: a second frame is ignored
        max_gap = 0;
        send_plain(4); send_bit(0);
        send_bits(32'h0000_F628, 16);
        send_bits(32'h0123_4567, 32);
        send_plain(80);
        #1;
        chk(n_sync == 1, "R7 no sync while held", n_sync, 1);
        chk(max_gap == 32, "R7 cadence unchanged while held", max_gap, 32);

        // Hold has no effect while hunting
        do_reset();
        send_plain(9); send_bit(0);
        send_bits(32'h0000_F628, 16);
        send_bits(32'h1234_5678, 32);
        #1;
        chk(strb_o && sync_o, "R8 hold ignored in hunt", {30'd0, strb_o, sync_o}, 32'd3);
        chk(word_o == 32'h1234_5678, "R8 aligned word", word_o, 32'h1234_5678);

        // Parity sense
        par_odd = 1;
        send_plain(64);
        #1;
        chk(((^last_word) ^ last_par) == 1'b1, "R9 R10 odd parity", {31'd0, last_par}, {31'd0, ~^last_word});
        par_odd = 0;
        send_plain(64);
        #1;
        chk(((^last_word) ^ last_par) == 1'b0, "R9 R10 even parity", {31'd0, last_par}, {31'd0, ^last_word});
        send_plain(40);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule